// File: doc/BRIEF.md
# Processor-Bus Peripheral Register Bank

This block is a small register bank that sits on an 8-bit processor bus with a 16-bit address and active-low strobes. It holds a fixed set of registers at consecutive local offsets. Each register is either a writable control register, whose value drives a slice of an output vector, or a read-only status register, which reflects a slice of an input vector. The register count, the kind, width and reset value of each register, and the base address are parameters. A build-time switch selects the request strobe that qualifies accesses. With the switch set, the bank answers the memory request. With it cleared, the bank answers the I/O request.

The offset field is the low `max(1, ceil(log2(NUM_REGS)))` address bits. The bank is selected when the qualifying request is low and the address bits above the offset field equal the base address shifted right by the field width. Reads are combinational. While a read select is active, the selected register's value, zero-extended to 8 bits, is driven on `rd_data` and `doe` is high. At all other times `rd_data` is released to high impedance, so a bus-side multiplexer should take `rd_data` only while `doe` is high. Writes take effect on the rising clock edge.

Top module: `busreg_bank`

## Requirements
- R1: On a rising edge with `reset` high, every control register loads its reset value masked to its width. Status slots of `cfg_q` always read 0.
- R2: A read of a control register in the window drives `doe` high and returns its current value on `rd_data`. `doe` is low whenever `rd_n` is high.
- R3: On each rising edge where the bank is selected, `wr_n` is low and the offset names a control register, that register loads `wr_data` masked to its width. Its bits above that width stay 0.
- R4: A read of a status register returns the live `sts_d` slice for its offset (bits `8*i+7 : 8*i`), masked to its width and zero-extended.
- R5: A write to a status register's offset changes no control register, and a later read of that offset still returns the input value.
- R6: For an offset at or above `NUM_REGS` inside the window, a read leaves `doe` low, and a write changes no control register.
- R7: An address outside the window produces no response. `doe` stays low, and writes change no register.
- R8: With `MEM_MAPPED=1`, only `mreq_n` qualifies accesses and `iorq_n` is ignored. With `MEM_MAPPED=0`, the roles of the two strobes are exchanged.
- R9: A control register holds its value on every edge where its write select is inactive. This includes edges where the request strobe is low but `wr_n` is high.
- R10: If `rd_n` and `wr_n` are both low on the same control register, `rd_data` shows the value held before the edge, and the register holds `wr_data` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| reset | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| wr_data | input | 8 | Bus write data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_data | output | 8 | Read data, high impedance when `doe` is low |
| doe | output | 1 | High while `rd_data` carries a register value |
| cfg_q | output | 8*NUM_REGS | Control register values, 8 bits per offset |
| sts_d | input | 8*NUM_REGS | Status inputs, 8 bits per offset |

## Verification
A read and a write can land on the same control register in one cycle, because `rd_n` and `wr_n` are independent strobes. The bench provokes this by pulling both strobes low together on one offset. The scoreboard item expects the value held before the edge on `rd_data`. The following `cfg_q` compare must then show the newly written value. Two instances, one per strobe mode, share the bus, so each access also checks that the instance whose strobe is idle stays silent.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  function automatic int loc_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input int w);
    logic [DATA_W:0] full;
    full = (9'd1 << w) - 9'd1;
    return full[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/busreg_decode.sv
module busreg_decode
  import busreg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit MEM_MAPPED = 1'b1,
  parameter logic [NUM_REGS-1:0] REG_IS_CFG = 5'b10101
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                mreq_n,
  input  logic                iorq_n,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int LOC_W = loc_bits(NUM_REGS);
  localparam logic [ADDR_W-1:0] BASE_HI = BASE_ADDR >> LOC_W;

  logic req_act;
  logic blk_sel;

  generate
    if (MEM_MAPPED) begin : g_mem
      assign req_act = ~mreq_n;
      logic strobe_unused;
      assign strobe_unused = iorq_n;
    end else begin : g_io
      assign req_act = ~iorq_n;
      logic strobe_unused;
      assign strobe_unused = mreq_n;
    end
  endgenerate

  assign blk_sel = req_act && (addr[ADDR_W-1:LOC_W] == BASE_HI[ADDR_W-1-LOC_W:0]);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    logic hit;
    assign hit = blk_sel && (addr[LOC_W-1:0] == LOC_W'(i));
    assign rd_sel[i] = hit && !rd_n;
    if (REG_IS_CFG[i]) begin : g_wr
      assign wr_sel[i] = hit && !wr_n;
    end else begin : g_nowr
      assign wr_sel[i] = 1'b0;
    end
  end
endmodule

// File: rtl/busreg_cfg.sv
module busreg_cfg
  import busreg_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [DATA_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] MASK = width_mask(WIDTH);

  always_ff @(posedge clk) begin
    if (reset)      q <= INIT & MASK;
    else if (wr_en) q <= wr_data & MASK;
  end
endmodule

// File: rtl/busreg_rdmux.sv
module busreg_rdmux
  import busreg_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input  logic [NUM_REGS-1:0]        rd_sel,
  input  logic [NUM_REGS*DATA_W-1:0] vals,
  output logic [DATA_W-1:0]          data,
  output logic                       any_sel
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel[i]) data = data | vals[i*DATA_W +: DATA_W];
    end
  end
  assign any_sel = |rd_sel;
endmodule

// File: rtl/busreg_bank.sv
module busreg_bank
  import busreg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit MEM_MAPPED = 1'b1,
  parameter logic [NUM_REGS-1:0] REG_IS_CFG = 5'b10101,
  parameter logic [NUM_REGS*4-1:0] REG_WIDTHS = {4'd8, 4'd3, 4'd4, 4'd8, 4'd8},
  parameter logic [NUM_REGS*DATA_W-1:0] REG_INIT = {8'h00, 8'h00, 8'h03, 8'h00, 8'hA5}
) (
  input  logic                       clk,
  input  logic                       reset,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic                       mreq_n,
  input  logic                       iorq_n,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       doe,
  output logic [NUM_REGS*DATA_W-1:0] cfg_q,
  input  logic [NUM_REGS*DATA_W-1:0] sts_d
);
  logic [NUM_REGS-1:0]        rd_sel;
  logic [NUM_REGS-1:0]        wr_sel;
  logic [NUM_REGS*DATA_W-1:0] vals;
  logic [DATA_W-1:0]          mux_data;
  logic                       sts_unused;

  assign sts_unused = ^sts_d;

  busreg_decode #(
    .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR),
    .MEM_MAPPED(MEM_MAPPED), .REG_IS_CFG(REG_IS_CFG)
  ) u_dec (
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int W = int'(REG_WIDTHS[i*4 +: 4]);
    if (REG_IS_CFG[i]) begin : g_cfg
      logic [DATA_W-1:0] q;
      busreg_cfg #(.WIDTH(W), .INIT(REG_INIT[i*DATA_W +: DATA_W])) u_cfg (
        .clk(clk), .reset(reset), .wr_en(wr_sel[i]),
        .wr_data(wr_data), .q(q)
      );
      assign vals[i*DATA_W +: DATA_W]  = q;
      assign cfg_q[i*DATA_W +: DATA_W] = q;
    end else begin : g_sts
      assign vals[i*DATA_W +: DATA_W]  = sts_d[i*DATA_W +: DATA_W] & width_mask(W);
      assign cfg_q[i*DATA_W +: DATA_W] = '0;
    end
  end

  busreg_rdmux #(.NUM_REGS(NUM_REGS)) u_mux (
    .rd_sel(rd_sel), .vals(vals), .data(mux_data), .any_sel(doe)
  );

  assign rd_data = doe ? mux_data : 'z;
endmodule

// File: rtl/busreg_bank_chk.sv
module busreg_bank_chk
  import busreg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit MEM_MAPPED = 1'b1,
  parameter logic [NUM_REGS-1:0] REG_IS_CFG = 5'b10101,
  parameter logic [NUM_REGS*4-1:0] REG_WIDTHS = {4'd8, 4'd3, 4'd4, 4'd8, 4'd8},
  parameter logic [NUM_REGS*DATA_W-1:0] REG_INIT = {8'h00, 8'h00, 8'h03, 8'h00, 8'hA5}
) (
  input logic                       clk,
  input logic                       reset,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       rd_n,
  input logic                       wr_n,
  input logic                       mreq_n,
  input logic                       iorq_n,
  input logic                       doe,
  input logic [NUM_REGS*DATA_W-1:0] cfg_q
);
  localparam int LOC_W = loc_bits(NUM_REGS);
  localparam logic [ADDR_W-1:0] BASE_HI = BASE_ADDR >> LOC_W;

  function automatic logic [NUM_REGS*DATA_W-1:0] reset_image();
    logic [NUM_REGS*DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (REG_IS_CFG[i])
        v[i*DATA_W +: DATA_W] = REG_INIT[i*DATA_W +: DATA_W] & width_mask(int'(REG_WIDTHS[i*4 +: 4]));
    return v;
  endfunction
  localparam logic [NUM_REGS*DATA_W-1:0] RST_IMG = reset_image();

  logic own_req, other_req, in_win, wr_any;
  assign own_req   = MEM_MAPPED ? !mreq_n : !iorq_n;
  assign other_req = MEM_MAPPED ? !iorq_n : !mreq_n;
  assign in_win    = addr[ADDR_W-1:LOC_W] == BASE_HI[ADDR_W-1-LOC_W:0];
  assign wr_any    = own_req && in_win && !wr_n;

  p_reset_val_r1: assert property (@(posedge clk) reset |=> cfg_q == RST_IMG);

  p_no_rd_no_doe_r2: assert property (@(posedge clk) disable iff (reset) rd_n |-> !doe);

  p_doe_in_window_r7: assert property (@(posedge clk) disable iff (reset)
    doe |-> (in_win && own_req && (int'(addr[LOC_W-1:0]) < NUM_REGS)));

  p_other_strobe_r8: assert property (@(posedge clk) disable iff (reset)
    (other_req && !own_req) |-> !doe);

  p_hold_r9: assert property (@(posedge clk) disable iff (reset) !wr_any |=> $stable(cfg_q));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    if (REG_IS_CFG[k]) begin : g_c
      p_write_load_r3: assert property (@(posedge clk) disable iff (reset)
        (wr_any && addr[LOC_W-1:0] == LOC_W'(k)) |=>
        cfg_q[k*DATA_W +: DATA_W] == ($past(wr_data) & width_mask(int'(REG_WIDTHS[k*4 +: 4]))));
    end else begin : g_s
      p_status_slot_zero_r1: assert property (@(posedge clk) disable iff (reset)
        cfg_q[k*DATA_W +: DATA_W] == '0);
    end
  end
endmodule

bind busreg_bank busreg_bank_chk #(
  .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR), .MEM_MAPPED(MEM_MAPPED),
  .REG_IS_CFG(REG_IS_CFG), .REG_WIDTHS(REG_WIDTHS), .REG_INIT(REG_INIT)
) u_chk (
  .clk(clk), .reset(reset), .addr(addr), .wr_data(wr_data),
  .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
  .doe(doe), .cfg_q(cfg_q)
);

// File: tb/busreg_bank_tb.sv
`timescale 1ns/1ps
module busreg_bank_tb;
  localparam int N = 5;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic rd_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
  logic [N*8-1:0] sts_d = '0;
  wire  [7:0] rd_m, rd_i;
  wire        doe_m, doe_i;
  wire  [N*8-1:0] cfg_m, cfg_i;

  always #2 clk = ~clk;

  busreg_bank #(.MEM_MAPPED(1'b1)) u_dut (
    .clk(clk), .reset(reset), .addr(addr), .wr_data(wr_data),
    .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_data(rd_m), .doe(doe_m), .cfg_q(cfg_m), .sts_d(sts_d));

  busreg_bank #(.MEM_MAPPED(1'b0)) u_dut_io (
    .clk(clk), .reset(reset), .addr(addr), .wr_data(wr_data),
    .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_data(rd_i), .doe(doe_i), .cfg_q(cfg_i), .sts_d(sts_d));

  // Model of the requirements: offsets 0,2,4 are control, 1,3 status.
  bit   is_cfg [N] = '{1, 0, 1, 0, 1};
  logic [7:0] msk [N] = '{8'hFF, 8'hFF, 8'h0F, 8'h07, 8'hFF};
  logic [7:0] init [N] = '{8'hA5, 8'h00, 8'h03, 8'h00, 8'h00};
  logic [7:0] mdl_m [N];
  logic [7:0] mdl_i [N];

  typedef struct {
    bit doe_m; logic [7:0] dat_m;
    bit doe_i; logic [7:0] dat_i;
    string tag;
  } item_t;
  item_t sb[$];
  event sample_ev;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items and compares them to the outputs.
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check8({7'd0, doe_m}, {7'd0, it.doe_m}, {it.tag, " mem doe"});
        if (it.doe_m) check8(rd_m, it.dat_m, {it.tag, " mem data"});
        check8({7'd0, doe_i}, {7'd0, it.doe_i}, {it.tag, " io doe"});
        if (it.doe_i) check8(rd_i, it.dat_i, {it.tag, " io data"});
      end
    end
  end

  function automatic bit in_win(input logic [15:0] a);
    return a[15:3] == 13'd8;
  endfunction

  function automatic logic [7:0] model_val(input bit mem, input int off);
    if (is_cfg[off]) return mem ? mdl_m[off] : mdl_i[off];
    return sts_d[off*8 +: 8] & msk[off];
  endfunction

  task automatic idle();
    rd_n = 1'b1; wr_n = 1'b1; mreq_n = 1'b1; iorq_n = 1'b1;
  endtask

  task automatic push_exp(input bit mem, input logic [15:0] a, input string tag);
    item_t it;
    int off;
    bit hit;
    off = int'(a[2:0]);
    hit = in_win(a) && off < N;
    it.doe_m = mem && hit;
    it.doe_i = !mem && hit;
    it.dat_m = hit ? model_val(1'b1, off) : 8'h00;
    it.dat_i = hit ? model_val(1'b0, off) : 8'h00;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(input bit mem, input logic [15:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_n = 1'b0; wr_n = 1'b1;
    mreq_n = !mem; iorq_n = mem;
    push_exp(mem, a, tag);
    #1 -> sample_ev;
    @(negedge clk); idle();
  endtask

  task automatic model_write(input bit mem, input logic [15:0] a, input logic [7:0] d);
    int off;
    off = int'(a[2:0]);
    if (in_win(a) && off < N && is_cfg[off]) begin
      if (mem) mdl_m[off] = d & msk[off];
      else     mdl_i[off] = d & msk[off];
    end
  endtask

  task automatic wr(input bit mem, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_n = 1'b0; rd_n = 1'b1;
    mreq_n = !mem; iorq_n = mem;
    @(negedge clk); idle();
    model_write(mem, a, d);
  endtask

  task automatic rdwr(input bit mem, input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    addr = a; wr_data = d; wr_n = 1'b0; rd_n = 1'b0;
    mreq_n = !mem; iorq_n = mem;
    push_exp(mem, a, tag);
    #1 -> sample_ev;
    @(negedge clk); idle();
    model_write(mem, a, d);
  endtask

  task automatic chk_cfg(input string tag);
    for (int i = 0; i < N; i++) begin
      check8(cfg_m[i*8 +: 8], is_cfg[i] ? mdl_m[i] : 8'h00, {tag, " mem cfg_q"});
      check8(cfg_i[i*8 +: 8], is_cfg[i] ? mdl_i[i] : 8'h00, {tag, " io cfg_q"});
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mdl_m[i] = init[i] & msk[i];
      mdl_i[i] = init[i] & msk[i];
    end
    sts_d = {8'hFF, 8'hFF, 8'h00, 8'h5A, 8'h00};
    repeat (3) @(negedge clk);
    reset = 1'b0;
    chk_cfg("R1 reset defaults");

    for (int i = 0; i < N; i++) rd(1'b1, 16'h0040 + 16'(i), "R2 R4 mem read after reset");
    for (int i = 0; i < N; i++) rd(1'b0, 16'h0040 + 16'(i), "R2 R4 io read after reset");

    wr(1'b1, 16'h0040, 8'h3C); wr(1'b1, 16'h0042, 8'hFF); wr(1'b1, 16'h0044, 8'h81);
    chk_cfg("R3 mem writes, io ignores");
    rd(1'b1, 16'h0040, "R3 mem readback 0");
    rd(1'b1, 16'h0042, "R3 mem readback narrow");
    rd(1'b1, 16'h0044, "R3 mem readback 4");
    wr(1'b0, 16'h0040, 8'h11); wr(1'b0, 16'h0042, 8'hE6);
    chk_cfg("R8 io writes, mem ignores");
    rd(1'b0, 16'h0042, "R8 io readback narrow");

    sts_d = {8'hC3, 8'hFF, 8'h00, 8'hA7, 8'h00};
    rd(1'b1, 16'h0041, "R4 live status");
    rd(1'b1, 16'h0043, "R4 narrow status masked");
    rd(1'b0, 16'h0043, "R4 io narrow status");

    wr(1'b1, 16'h0041, 8'h77); wr(1'b1, 16'h0043, 8'h77);
    chk_cfg("R5 status write no effect");
    rd(1'b1, 16'h0041, "R5 status still input");

    for (int o = 5; o < 8; o++) begin
      wr(1'b1, 16'h0040 + 16'(o), 8'hEE);
      rd(1'b1, 16'h0040 + 16'(o), "R6 unused offset no doe");
    end
    chk_cfg("R6 unused offset writes");

    wr(1'b1, 16'h0048, 8'h99); wr(1'b1, 16'h003F, 8'h99); wr(1'b0, 16'h1040, 8'h99);
    rd(1'b1, 16'h0048, "R7 above window");
    rd(1'b1, 16'h003F, "R7 below window");
    rd(1'b0, 16'h0840, "R7 high address bit");
    chk_cfg("R7 outside writes");

    // R9: request low, wr_n high, changing data -> hold.
    @(negedge clk);
    addr = 16'h0040; wr_data = 8'h55; mreq_n = 1'b0; iorq_n = 1'b0;
    repeat (3) @(negedge clk);
    idle();
    chk_cfg("R9 hold without wr_n");

    // R10: simultaneous read and write.
    rdwr(1'b1, 16'h0044, 8'h6B, "R10 read sees old value");
    chk_cfg("R10 write lands after edge");
    rd(1'b1, 16'h0044, "R10 new value read");

    // R1 again: reset mid-run restores defaults.
    @(negedge clk); reset = 1'b1;
    @(negedge clk); reset = 1'b0;
    for (int i = 0; i < N; i++) begin
      mdl_m[i] = init[i] & msk[i];
      mdl_i[i] = init[i] & msk[i];
    end
    chk_cfg("R1 second reset");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule